// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for every received frame, whether its 48-bit destination address should be kept or thrown away. The address arrives in one word with a valid strobe. One cycle later the block answers with a registered keep/drop decision. Unicast addresses are checked against a single exact-match entry and against a 64-bit unicast hash table. Multicast addresses are checked against their own 64-bit hash table. Two promiscuous controls, one per address class, let a whole class through without looking anything up.

The hash index is six bits wide. Each index bit is the parity of the eight address bits that lie six positions apart. Configuration uses a simple 32-bit register write port. Each hash table is loaded as a lower and an upper 32-bit half. The exact-match entry is loaded as a low word and a high word, and the high word also carries the entry's enable bit. Software is expected to use the exact-match entry only when exactly one unicast address is wanted. Otherwise it disables the entry and programs the unicast hash table.

Top module: `dest_addr_filter`

## Requirements
- R1: A lookup presented with `da_valid` high gives `dec_valid` high on the next clock cycle. `dec_accept` is never high while `dec_valid` is low.
- R2: The address is packed with the first received byte in bits 7:0. Bit 0 of `da_addr` marks the address as multicast (1) or unicast (0), and that bit selects which table is consulted.
- R3: The hash index bit i (i = 0..5) is the XOR of address bits i, i+6, i+12, ..., i+42. The frame hits when table bit [index] is 1.
- R4: A unicast address is accepted when the exact-match entry is enabled and equals the address. The entry does not apply to multicast addresses. Clearing the enable bit removes its effect.
- R5: A unicast address is accepted when its hash index selects a set bit in the unicast table.
- R6: A multicast address is checked only against the multicast table. A bit set only in the unicast table never admits a multicast address, and the reverse also holds.
- R7: The register map (word address on `cfg_addr`) is as follows. 0 and 1 hold unicast table bits 31:0 and 63:32. 2 and 3 hold multicast table bits 31:0 and 63:32. 4 holds exact-match address bits 31:0. 5 holds exact-match address bits 47:32 in data bits 15:0, plus the enable in data bit 16. 6 holds the modes: bit 0 is unicast promiscuous and bit 1 is multicast promiscuous. Writing one half of a table leaves the other half unchanged.
- R8: With unicast promiscuous set, every unicast address is accepted. Multicast decisions are unaffected.
- R9: With multicast promiscuous set, every multicast address is accepted. Unicast decisions are unaffected.
- R10: Reset clears both tables, disables the exact-match entry and clears both promiscuous bits, so every lookup is dropped.
- R11: A write to word address 7 changes no configuration state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address valid |
| da_addr | input | 48 | Destination address, first byte in bits 7:0 |
| dec_valid | output | 1 | Decision valid, one cycle after `da_valid` |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop |

## Verification
The tables are loaded so that some hash indices are set in one table only. Unicast and multicast addresses landing on the same index then show whether the class bit really steers the lookup. Several addresses are built so that address bits cancel in the parity fold or land in the upper table half. These confirm the six-apart grouping and the mapping of the high register. The exact-match address is also tried with its multicast bit set, and again after its enable is cleared, to separate an exact hit from a hash hit. Each promiscuous bit is set on its own and probed with both classes, so a crossed control would show up.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int ADDR_W = 48;
  localparam int IDX_W  = 6;
  localparam int REG_W  = 32;
  localparam int CFG_AW = 3;
  localparam int TBL_N  = 1 << IDX_W;
  localparam int FOLDS  = ADDR_W / IDX_W;
  localparam int EM_HI_W = ADDR_W - REG_W;

  localparam logic [CFG_AW-1:0] RA_UC_LO = 3'd0;
  localparam logic [CFG_AW-1:0] RA_UC_HI = 3'd1;
  localparam logic [CFG_AW-1:0] RA_MC_LO = 3'd2;
  localparam logic [CFG_AW-1:0] RA_MC_HI = 3'd3;
  localparam logic [CFG_AW-1:0] RA_EM_LO = 3'd4;
  localparam logic [CFG_AW-1:0] RA_EM_HI = 3'd5;
  localparam logic [CFG_AW-1:0] RA_MODE  = 3'd6;

  typedef struct packed {
    logic [TBL_N-1:0]  uc_tbl;
    logic [TBL_N-1:0]  mc_tbl;
    logic [ADDR_W-1:0] em_addr;
    logic              em_en;
    logic              uc_prom;
    logic              mc_prom;
  } daf_cfg_t;
endpackage

// File: rtl/daf_hash.sv
module daf_hash
  import daf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = IDX_W
) (
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] idx
);
  localparam int NF = AW / IW;

  for (genvar i = 0; i < IW; i++) begin : g_bit
    logic [NF-1:0] taps;
    for (genvar k = 0; k < NF; k++) begin : g_tap
      assign taps[k] = addr[i + k*IW];
    end
    assign idx[i] = ^taps;   // R3
  end
endmodule

// File: rtl/daf_cfg_regs.sv
module daf_cfg_regs
  import daf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output daf_cfg_t          cfg
);
  daf_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      unique case (cfg_addr)
        RA_UC_LO: cfg_d.uc_tbl[REG_W-1:0]     = cfg_wdata;
        RA_UC_HI: cfg_d.uc_tbl[TBL_N-1:REG_W] = cfg_wdata;
        RA_MC_LO: cfg_d.mc_tbl[REG_W-1:0]     = cfg_wdata;
        RA_MC_HI: cfg_d.mc_tbl[TBL_N-1:REG_W] = cfg_wdata;
        RA_EM_LO: cfg_d.em_addr[REG_W-1:0]    = cfg_wdata;
        RA_EM_HI: begin
          cfg_d.em_addr[ADDR_W-1:REG_W] = cfg_wdata[EM_HI_W-1:0];
          cfg_d.em_en                   = cfg_wdata[EM_HI_W];
        end
        RA_MODE: begin
          cfg_d.uc_prom = cfg_wdata[0];
          cfg_d.mc_prom = cfg_wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == 3'd7 |=> $stable(cfg_q)); // R11
  AST_UC_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == RA_UC_HI |=> $stable(cfg_q.uc_tbl[REG_W-1:0])); // R7
  AST_MC_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == RA_MC_LO |=> $stable(cfg_q.mc_tbl[TBL_N-1:REG_W])); // R7
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              da_valid,
  input  logic [ADDR_W-1:0] da_addr,
  output logic              dec_valid,
  output logic              dec_accept
);
  daf_cfg_t        cfg;
  logic [IDX_W-1:0] hidx;
  logic            is_mc, em_hit, tbl_hit, keep;
  logic            vld_q, acc_q, vld_d, acc_d;

  daf_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg       (cfg)
  );

  daf_hash #(.AW(ADDR_W), .IW(IDX_W)) u_hash (
    .addr (da_addr),
    .idx  (hidx)
  );

  // Class decision and table lookup
  always_comb begin
    is_mc   = da_addr[0];
    em_hit  = cfg.em_en && (da_addr == cfg.em_addr);
    tbl_hit = is_mc ? cfg.mc_tbl[hidx] : cfg.uc_tbl[hidx];
    if (is_mc) keep = cfg.mc_prom || tbl_hit;
    else       keep = cfg.uc_prom || em_hit || tbl_hit;
    vld_d = da_valid;
    acc_d = da_valid && keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      acc_q <= acc_d;
    end
  end

  assign dec_valid  = vld_q;
  assign dec_accept = acc_q;

  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept); // R1
  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> dec_valid); // R1
  AST_UC_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid && !da_addr[0] && cfg.uc_prom |=> dec_accept); // R8
  AST_MC_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid && da_addr[0] && cfg.mc_prom |=> dec_accept); // R9
  AST_EXACT_HIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid && !da_addr[0] && cfg.em_en && da_addr == cfg.em_addr |=> dec_accept); // R4
  AST_MC_EMPTY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid && da_addr[0] && !cfg.mc_prom && cfg.mc_tbl == '0 |=> !dec_accept); // R6
endmodule

// File: tb/sim_dest_addr_filter.sv
module sim_dest_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        da_valid;
  logic [47:0] da_addr;
  logic        dec_valid, dec_accept;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  dest_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_addr(da_addr),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // {expected accept, address}; R3/R5/R6/R7 vectors, hash indices noted
  localparam logic [48:0] VEC [0:11] = '{
    {1'b1, 48'h0000_0000_0002},  // uc idx2 hit (R5)
    {1'b1, 48'h0000_0000_0028},  // uc idx40, upper half (R7)
    {1'b0, 48'h0000_0000_0004},  // uc idx4 miss
    {1'b1, 48'h8000_0000_0040},  // exact match (R4)
    {1'b0, 48'h8000_0000_0041},  // mc idx32, exact not applied (R4)
    {1'b1, 48'h0000_0000_0001},  // mc idx1 hit (R6)
    {1'b1, 48'h0000_0000_003F},  // mc idx63 upper half (R7)
    {1'b0, 48'h0000_0000_0003},  // mc idx3 miss
    {1'b1, 48'h0000_0000_0083},  // mc fold cancels -> idx1 (R3)
    {1'b0, 48'h0400_0000_0003},  // mc idx2, only in uc table (R6)
    {1'b1, 48'h0800_0000_0000},  // uc bit43 -> idx2 (R3)
    {1'b0, 48'h0000_0000_0040}   // uc idx1, only in mc table (R6)
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual {valid,accept}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [47:0] a, input logic e, input string tag);
    @(negedge clk);
    da_addr = a; da_valid = 1'b1;
    @(negedge clk);
    da_valid = 1'b0;
    chk(dec_valid === 1'b1 && dec_accept === e, tag,
        {dec_valid, dec_accept}, {1'b1, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    da_valid = 1'b0; da_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dec_valid === 1'b0 && dec_accept === 1'b0, "R1 idle",
        {dec_valid, dec_accept}, 2'b00);
    look(48'h0000_0000_0002, 1'b0, "R10 uc after reset");
    look(48'h0000_0000_0001, 1'b0, "R10 mc after reset");
    look(48'h8000_0000_0040, 1'b0, "R10 exact disabled after reset");

    wr(3'd0, 32'h0000_0004);
    wr(3'd1, 32'h0000_0100);
    wr(3'd2, 32'h0000_0002);
    wr(3'd3, 32'h8000_0000);
    wr(3'd4, 32'h0000_0040);
    wr(3'd5, 32'h0001_8000);

    for (int i = 0; i < 12; i++)
      look(VEC[i][47:0], VEC[i][48], $sformatf("R2 R3 vector %0d", i));

    wr(3'd7, 32'hFFFF_FFFF);
    look(48'h0000_0000_0004, 1'b0, "R11 uc after unmapped write");
    look(48'h0000_0000_0003, 1'b0, "R11 mc after unmapped write");
    look(48'h8000_0000_0040, 1'b1, "R11 exact kept");

    wr(3'd6, 32'h1);
    look(48'h0000_0000_0004, 1'b1, "R8 uc promisc");
    look(48'h0000_0000_0003, 1'b0, "R8 mc unaffected");
    wr(3'd6, 32'h2);
    look(48'h0000_0000_0003, 1'b1, "R9 mc promisc");
    look(48'h0000_0000_0004, 1'b0, "R9 uc unaffected");
    wr(3'd6, 32'h0);

    wr(3'd5, 32'h0000_8000);
    look(48'h8000_0000_0040, 1'b0, "R4 exact disabled");
    look(48'h0000_0000_0002, 1'b1, "R5 hash still active");

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    look(48'h0000_0000_0002, 1'b0, "R10 uc table cleared");
    look(48'h0000_0000_003F, 1'b0, "R10 mc table cleared");
    look(48'h0000_0000_0004, 1'b0, "R10 promisc cleared");
    finish_run();
  end
endmodule